// File: doc/BRIEF.md
# Address Decode Window Unit

This unit steers each 32-bit CPU transaction address to one of several target ports. Five windows can be programmed independently. Each window holds an enable flag, a 4-bit target code, and three 16-bit fields: base, size and remap. The three fields describe address bits 31:16, so each window is aligned to 64 KB.

The size field works directly as a mask. It is written as a run of ones starting at bit 0, and the number of ones gives the window length in 64 KB units; a field value of 0x00FF covers 16 MB. Software writes (bytes / 64 KB) - 1. An address hits a window when its upper bits agree with the base on every position outside the mask. The forwarded address takes the remap bits outside the mask and the address's own bits inside it; the low 16 bits pass through unchanged.

Every cycle the unit compares the presented address against all windows. One cycle later it reports a hit flag, the winning window index, its target code and the translated address. A simple write port and a combinational read port give access to the window fields. To reprogram a window, software clears its enable, writes base, remap and size, and then writes target and enable in one write.

Top module: `addr_win_dec`

## Requirements
- R1: After reset, window 0 is enabled with target 0 (DRAM), base 0, size field 0x07FF (128 MB) and remap 0. Windows 1 to 4 read back as all zero and never match.
- R2: An enabled window matches when `((addr[31:16] ^ base) & ~size) == 0`.
- R3: A window whose enable bit is clear never matches, whatever its other fields hold.
- R4: When several enabled windows match, the lowest-numbered window is reported.
- R5: When no window matches, `hit_o` is 0 and `win_o`, `tgt_o` and `out_addr_o` are all zero.
- R6: On a hit, `out_addr_o` equals `{(remap & ~size) | (addr[31:16] & size), addr[15:0]}` for the winning window.
- R7: Decode results appear on the outputs exactly one clock after the address is sampled. Back-to-back addresses give back-to-back results.
- R8: A register write takes effect for an address sampled on the edge after the write. An address presented in the same cycle as the write is decoded with the old configuration.
- R9: Register select codes are 0 control, 1 base, 2 size and 3 remap. In the control word, bit 0 is the enable and bits 7:4 are the target. All other control bits are ignored on write and read back as zero. Writes or reads naming a window index of 5 or more have no effect and read zero.
- R10: `tgt_o` carries the 4-bit target code of the winning window unchanged. The codes are DRAM 0, internal registers 1, PCIe 2, PCIe over chip link 3, boot ROM 4, external chip link 5, secure RAM 7 and interconnect registers 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Incoming transaction address |
| wr_en_i | input | 1 | Register write strobe |
| wr_win_i | input | 3 | Window index for the write |
| wr_sel_i | input | 2 | Register select for the write (0 ctrl, 1 base, 2 size, 3 remap) |
| wr_data_i | input | 16 | Write data |
| rd_win_i | input | 3 | Window index for the read |
| rd_sel_i | input | 2 | Register select for the read |
| rd_data_o | output | 16 | Read data (combinational) |
| hit_o | output | 1 | Registered hit flag |
| win_o | output | 3 | Index of the winning window |
| tgt_o | output | 4 | Target code of the winning window |
| out_addr_o | output | 32 | Translated address |

## Verification
A corrupted enable, base or size bit in a window shows up on `hit_o` and `win_o` one clock after an address that falls near that window's edge is presented. A bad remap or mask bit shows up in the upper half of `out_addr_o` on that same cycle. The read port exposes every stored field combinationally, so a register written into the wrong window or the wrong field can be seen in the same cycle it is read. Same-cycle write-and-decode checks and priority overlap checks catch results that appear one cycle too early or a chain that prefers the wrong window.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_SIZE  = 2'd2,
    SEL_REMAP = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_TGT_LSB = 4;

  typedef enum logic [3:0] {
    TGT_DRAM     = 4'd0,
    TGT_INT_REG  = 4'd1,
    TGT_PCIE     = 4'd2,
    TGT_PCIE_LNK = 4'd3,
    TGT_BOOT_ROM = 4'd4,
    TGT_EXT_LNK  = 4'd5,
    TGT_SEC_RAM  = 4'd7,
    TGT_IC_REG   = 4'd8
  } tgt_e;
endpackage

// File: rtl/adw_regs.sv
module adw_regs
  import addr_win_pkg::*;
#(
  parameter int NWIN  = 5,
  parameter int FLD_W = 16,
  parameter int TGT_W = 4,
  parameter logic [FLD_W-1:0] RST0_SIZE = 16'h07FF,
  localparam int WIN_W = $clog2(NWIN)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [WIN_W-1:0]            wr_win_i,
  input  logic [1:0]                  wr_sel_i,
  input  logic [FLD_W-1:0]            wr_data_i,
  input  logic [WIN_W-1:0]            rd_win_i,
  input  logic [1:0]                  rd_sel_i,
  output logic [FLD_W-1:0]            rd_data_o,
  output logic [NWIN-1:0]             en_o,
  output logic [NWIN-1:0][TGT_W-1:0]  tgt_o,
  output logic [NWIN-1:0][FLD_W-1:0]  base_o,
  output logic [NWIN-1:0][FLD_W-1:0]  size_o,
  output logic [NWIN-1:0][FLD_W-1:0]  remap_o
);
  reg_sel_e wsel, rsel;
  assign wsel = reg_sel_e'(wr_sel_i);
  assign rsel = reg_sel_e'(rd_sel_i);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam bit IS0 = (w == 0);
    logic             en_q;
    logic [TGT_W-1:0] tgt_q;
    logic [FLD_W-1:0] base_q, size_q, remap_q;
    logic             sel_w;

    assign sel_w = wr_en_i && (32'(wr_win_i) == w);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q    <= IS0;
        tgt_q   <= '0;
        base_q  <= '0;
        size_q  <= IS0 ? RST0_SIZE : '0;
        remap_q <= '0;
      end else if (sel_w) begin
        case (wsel)
          SEL_CTRL: begin
            en_q  <= wr_data_i[CTRL_EN_BIT];
            tgt_q <= wr_data_i[CTRL_TGT_LSB +: TGT_W];
          end
          SEL_BASE:  base_q  <= wr_data_i;
          SEL_SIZE:  size_q  <= wr_data_i;
          SEL_REMAP: remap_q <= wr_data_i;
          default: ;
        endcase
      end
    end

    assign en_o[w]    = en_q;
    assign tgt_o[w]   = tgt_q;
    assign base_o[w]  = base_q;
    assign size_o[w]  = size_q;
    assign remap_o[w] = remap_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (32'(rd_win_i) == i) begin
        case (rsel)
          SEL_CTRL: begin
            rd_data_o[CTRL_EN_BIT] = en_o[i];
            rd_data_o[CTRL_TGT_LSB +: TGT_W] = tgt_o[i];
          end
          SEL_BASE:  rd_data_o = base_o[i];
          SEL_SIZE:  rd_data_o = size_o[i];
          SEL_REMAP: rd_data_o = remap_o[i];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adw_match.sv
module adw_match #(
  parameter int FLD_W = 16
) (
  input  logic             en_i,
  input  logic [FLD_W-1:0] addr_hi_i,
  input  logic [FLD_W-1:0] base_i,
  input  logic [FLD_W-1:0] size_i,
  input  logic [FLD_W-1:0] remap_i,
  output logic             hit_o,
  output logic [FLD_W-1:0] xl_hi_o
);
  // size is a low-justified run of ones: bits under it are offset, the rest must equal base
  assign hit_o   = en_i && (((addr_hi_i ^ base_i) & ~size_i) == '0);
  assign xl_hi_o = (remap_i & ~size_i) | (addr_hi_i & size_i);
endmodule

// File: rtl/adw_pick.sv
module adw_pick #(
  parameter int NWIN  = 5,
  parameter int FLD_W = 16,
  parameter int TGT_W = 4,
  localparam int WIN_W = $clog2(NWIN)
) (
  input  logic [NWIN-1:0]            match_i,
  input  logic [NWIN-1:0][FLD_W-1:0] xl_hi_i,
  input  logic [NWIN-1:0][TGT_W-1:0] tgt_i,
  output logic                       hit_o,
  output logic [WIN_W-1:0]           idx_o,
  output logic [TGT_W-1:0]           tgt_o,
  output logic [FLD_W-1:0]           xl_hi_o
);
  // scan high to low so the lowest index is written last and wins
  always_comb begin
    hit_o   = 1'b0;
    idx_o   = '0;
    tgt_o   = '0;
    xl_hi_o = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o   = 1'b1;
        idx_o   = WIN_W'(i);
        tgt_o   = tgt_i[i];
        xl_hi_o = xl_hi_i[i];
      end
    end
  end
endmodule

// File: rtl/addr_win_dec.sv
module addr_win_dec
  import addr_win_pkg::*;
#(
  parameter int NWIN   = 5,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int TGT_W  = 4,
  localparam int FLD_W = ADDR_W - OFS_W,
  localparam int WIN_W = $clog2(NWIN),
  parameter logic [FLD_W-1:0] RST0_SIZE = 16'h07FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WIN_W-1:0]  wr_win_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [FLD_W-1:0]  wr_data_i,
  input  logic [WIN_W-1:0]  rd_win_i,
  input  logic [1:0]        rd_sel_i,
  output logic [FLD_W-1:0]  rd_data_o,
  output logic              hit_o,
  output logic [WIN_W-1:0]  win_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [ADDR_W-1:0] out_addr_o
);
  logic [NWIN-1:0]            win_en;
  logic [NWIN-1:0][TGT_W-1:0] win_tgt;
  logic [NWIN-1:0][FLD_W-1:0] win_base, win_size, win_remap, win_xl;
  logic [NWIN-1:0]            win_match;

  logic             pk_hit;
  logic [WIN_W-1:0] pk_idx;
  logic [TGT_W-1:0] pk_tgt;
  logic [FLD_W-1:0] pk_hi;

  adw_regs #(
    .NWIN(NWIN), .FLD_W(FLD_W), .TGT_W(TGT_W), .RST0_SIZE(RST0_SIZE)
  ) regs_i (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_win_i, .wr_sel_i, .wr_data_i,
    .rd_win_i, .rd_sel_i, .rd_data_o,
    .en_o(win_en), .tgt_o(win_tgt), .base_o(win_base),
    .size_o(win_size), .remap_o(win_remap)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    adw_match #(.FLD_W(FLD_W)) match_i (
      .en_i(win_en[w]),
      .addr_hi_i(addr_i[ADDR_W-1:OFS_W]),
      .base_i(win_base[w]),
      .size_i(win_size[w]),
      .remap_i(win_remap[w]),
      .hit_o(win_match[w]),
      .xl_hi_o(win_xl[w])
    );
  end

  adw_pick #(.NWIN(NWIN), .FLD_W(FLD_W), .TGT_W(TGT_W)) pick_i (
    .match_i(win_match), .xl_hi_i(win_xl), .tgt_i(win_tgt),
    .hit_o(pk_hit), .idx_o(pk_idx), .tgt_o(pk_tgt), .xl_hi_o(pk_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o      <= 1'b0;
      win_o      <= '0;
      tgt_o      <= '0;
      out_addr_o <= '0;
    end else begin
      hit_o      <= pk_hit;
      win_o      <= pk_idx;
      tgt_o      <= pk_tgt;
      out_addr_o <= pk_hit ? {pk_hi, addr_i[OFS_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/addr_win_dec_chk.sv
module addr_win_dec_chk #(
  parameter int NWIN   = 5,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int TGT_W  = 4,
  localparam int FLD_W = ADDR_W - OFS_W,
  localparam int WIN_W = $clog2(NWIN)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       hit_o,
  input logic [WIN_W-1:0]           win_o,
  input logic [TGT_W-1:0]           tgt_o,
  input logic [ADDR_W-1:0]          out_addr_o,
  input logic [NWIN-1:0]            win_en_i,
  input logic [NWIN-1:0][FLD_W-1:0] win_size_i
);
  logic [NWIN-1:0]            en_d;
  logic [NWIN-1:0][FLD_W-1:0] size_d;
  logic [FLD_W-1:0]           ahi_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d   <= '0;
      size_d <= '0;
      ahi_d  <= '0;
    end else begin
      en_d   <= win_en_i;
      size_d <= win_size_i;
      ahi_d  <= addr_i[ADDR_W-1:OFS_W];
    end
  end

  // R5
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (out_addr_o == '0 && tgt_o == '0 && win_o == '0));

  // R7
  ofs_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> out_addr_o[OFS_W-1:0] == $past(addr_i[OFS_W-1:0]));

  // R3
  enabled_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> en_d[win_o]);

  // R4
  win_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (32'(win_o) < NWIN));

  // R6
  inner_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (((out_addr_o[ADDR_W-1:OFS_W] ^ ahi_d) & size_d[win_o]) == '0));
endmodule

bind addr_win_dec addr_win_dec_chk #(
  .NWIN(NWIN), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .TGT_W(TGT_W)
) chk_i (
  .clk_i, .rst_ni, .addr_i, .hit_o, .win_o, .tgt_o, .out_addr_o,
  .win_en_i(win_en), .win_size_i(win_size)
);

// File: tb/addr_win_dec_tb_top.sv
module addr_win_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_win = '0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_win = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        hit;
  logic [2:0]  win;
  logic [3:0]  tgt;
  logic [31:0] oaddr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench-side image of what has been programmed
  bit          m_en[5];
  logic [3:0]  m_tgt[5];
  logic [15:0] m_base[5], m_size[5], m_remap[5];

  always #5 clk = ~clk;

  addr_win_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .wr_en_i(wr_en), .wr_win_i(wr_win), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_win_i(rd_win), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .hit_o(hit), .win_o(win), .tgt_o(tgt), .out_addr_o(oaddr)
  );

  function automatic void model_init();
    for (int i = 0; i < 5; i++) begin
      m_en[i] = (i == 0); m_tgt[i] = '0; m_base[i] = '0;
      m_size[i] = (i == 0) ? 16'h07FF : 16'h0; m_remap[i] = '0;
    end
  endfunction

  function automatic void model_wr(int w, int s, logic [15:0] d);
    if (w >= 5) return;
    case (s)
      0: begin m_en[w] = d[0]; m_tgt[w] = d[7:4]; end
      1: m_base[w] = d;
      2: m_size[w] = d;
      default: m_remap[w] = d;
    endcase
  endfunction

  function automatic logic [39:0] model_dec(logic [31:0] a);
    // returns {hit, win[2:0], tgt[3:0], addr[31:0]}
    for (int i = 0; i < 5; i++) begin
      if (m_en[i] && (((a[31:16] ^ m_base[i]) & ~m_size[i]) == 16'h0))
        return {1'b1, 3'(i), m_tgt[i],
                (m_remap[i] & ~m_size[i]) | (a[31:16] & m_size[i]), a[15:0]};
    end
    return 40'h0;
  endfunction

  task automatic cmp(logic [39:0] exp, string req);
    total++;
    if ({hit, win, tgt, oaddr} !== exp) begin
      bad++;
      $display("FAIL %s: got hit=%0b win=%0d tgt=%0d addr=%h exp hit=%0b win=%0d tgt=%0d addr=%h",
               req, hit, win, tgt, oaddr, exp[39], exp[38:36], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic wr(int w, int s, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = 3'(w); wr_sel = 2'(s); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(w, s, d);
  endtask

  task automatic probe(logic [31:0] a, string req);
    @(negedge clk); addr = a;
    @(negedge clk); cmp(model_dec(a), req);
  endtask

  task automatic rd(int w, int s, logic [15:0] exp, string req);
    rd_win = 3'(w); rd_sel = 2'(s);
    #1;
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s: rd win=%0d sel=%0d got=%h exp=%h", req, w, s, rd_data, exp);
    end
  endtask

  task automatic t_reset();
    total++;
    if ({hit, win, tgt, oaddr} !== 40'h0) begin
      bad++;
      $display("FAIL R1: outputs after reset got=%h exp=0", {hit, win, tgt, oaddr});
    end
    rd(0, 0, 16'h0001, "R1 ctrl0");
    rd(0, 2, 16'h07FF, "R1 size0");
    rd(0, 1, 16'h0000, "R1 base0");
    rd(3, 0, 16'h0000, "R1 ctrl3");
    probe(32'h07FF_1234, "R1 top of win0");
    cmp({1'b1, 3'd0, 4'd0, 32'h07FF_1234}, "R1 hit win0");
    probe(32'h0800_0000, "R5 just past win0");
    cmp(40'h0, "R5 miss zeros");
  endtask

  task automatic t_remap();
    // R6 / R10: 128 KB window at 0xF0000000 remapped to 0x1FFE0000, secure RAM
    wr(3, 0, 16'h0070);
    wr(3, 1, 16'hF000);
    wr(3, 3, 16'h1FFE);
    wr(3, 2, 16'h0001);
    wr(3, 0, 16'h0071);
    probe(32'hF001_2345, "R6 remap second 64K");
    cmp({1'b1, 3'd3, 4'd7, 32'h1FFF_2345}, "R6 R10 remap value");
    probe(32'hF000_0010, "R6 remap first 64K");
    probe(32'hF002_0000, "R2 above window");
    probe(32'hEFFF_FFFF, "R2 below window");
  endtask

  task automatic t_disable();
    wr(3, 0, 16'h0070);
    rd(3, 0, 16'h0070, "R9 target kept with enable off");
    probe(32'hF000_0010, "R3 disabled window");
    cmp(40'h0, "R3 no match when disabled");
  endtask

  task automatic t_priority();
    wr(1, 2, 16'h00FF);
    wr(1, 3, 16'h4000);
    wr(1, 0, 16'h0021);
    probe(32'h0000_1234, "R4 win0 beats win1");
    cmp({1'b1, 3'd0, 4'd0, 32'h0000_1234}, "R4 lowest wins");
    wr(0, 0, 16'h0000);
    probe(32'h0000_1234, "R4 win1 after win0 off");
    cmp({1'b1, 3'd1, 4'd2, 32'h4000_1234}, "R4 R6 win1 remap");
    wr(4, 1, 16'hD800);
    wr(4, 3, 16'hD800);
    wr(4, 0, 16'h0081);
    probe(32'hD800_FFFC, "R10 target 8");
    probe(32'hD801_0000, "R2 one past 64K window");
  endtask

  task automatic t_stream();
    logic [39:0] e1, e2;
    e1 = model_dec(32'h0000_0040);
    e2 = model_dec(32'hD800_0004);
    @(negedge clk); addr = 32'h0000_0040;
    @(negedge clk); addr = 32'hD800_0004; cmp(e1, "R7 first of pair");
    @(negedge clk); cmp(e2, "R7 second of pair");
  endtask

  task automatic t_same_cycle();
    logic [39:0] old_e;
    old_e = model_dec(32'h0000_0100);
    @(negedge clk);
    wr_en = 1'b1; wr_win = 3'd0; wr_sel = 2'd0; wr_data = 16'h0001;
    addr = 32'h0000_0100;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(0, 0, 16'h0001);
    cmp(old_e, "R8 same cycle sees old config");
    @(negedge clk);
    cmp({1'b1, 3'd0, 4'd0, 32'h0000_0100}, "R8 next cycle sees new config");
  endtask

  task automatic t_regs();
    wr(2, 0, 16'hFFF0);
    rd(2, 0, 16'h00F0, "R9 ctrl masking");
    wr(2, 1, 16'hA5A5);
    rd(2, 1, 16'hA5A5, "R9 base readback");
    wr(6, 2, 16'h1234);
    rd(6, 2, 16'h0000, "R9 out of range read");
    rd(2, 2, 16'h0000, "R9 out of range write ignored");
    probe(32'hA5A5_0000, "R3 R9 win2 disabled");
  endtask

  initial begin
    model_init();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_remap();
    t_disable();
    t_priority();
    t_stream();
    t_same_cycle();
    t_regs();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule